// File: doc/BRIEF.md
# Parking Occupancy BCD Counter

This block keeps the number of cars inside a parking lot that holds up to 100 vehicles. Two switch inputs report gate activity: the entry switch closes when the entry barrier comes fully down after a car has gone in, and the exit switch closes the same way at the exit barrier. Each closure is brought into the clock domain and turned into a single count event. The occupancy is held as three cascaded decimal digits that count up and down with carry and borrow between digits.

Two lamp outputs are decoded from the count against the capacity. The vacancy lamp is lit while spaces remain, and the full lamp is lit when the lot holds exactly its capacity. A synchronous clear and a checked parallel preset let the surrounding logic correct the count, for example after a manual recount.

Top module: `park_occupancy`

## Requirements
- R1: Reset (`rst`) or `clear_i` sampled high at a rising clock edge sets the count to 000. `clear_i` takes priority over the preset and over gate events in the same cycle.
- R2: A rising transition on `entry_sw_i` adds one to the count. The new count appears after the third rising clock edge that samples the switch high. A switch that stays closed for many cycles still counts only once.
- R3: A rising transition on `exit_sw_i` subtracts one from the count, with the same latency as R2.
- R4: `count_o` is BCD with hundreds in bits [11:8], tens in [7:4] and ones in [3:0]. A digit going up past 9 wraps to 0 and carries into the next digit (009 to 010, 099 to 100). A digit going down past 0 wraps to 9 and borrows (010 to 009, 100 to 099). No digit ever holds a value from 10 to 15.
- R5: An entry event while the count is 100 is ignored, and an exit event while the count is 000 is ignored. The count never leaves the range 000 to 100.
- R6: Entry and exit events in the same clock cycle cancel, and the count is unchanged.
- R7: With `preset_en_i` high and `clear_i` low, a valid BCD `preset_val_i` from 000 to 100 is loaded at the clock edge. The preset overrides any gate event in that cycle.
- R8: A preset value that has any digit above 9, or that is above 100, is rejected. The count keeps its previous value, and gate events in that cycle are dropped.
- R9: `vacancy_o` is 1 and `full_o` is 0 while the count is 000 to 099. `full_o` is 1 and `vacancy_o` is 0 when the count is 100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| entry_sw_i | input | 1 | Entry gate fully-down switch, asynchronous |
| exit_sw_i | input | 1 | Exit gate fully-down switch, asynchronous |
| clear_i | input | 1 | Synchronous clear of the count |
| preset_en_i | input | 1 | Load request for preset_val_i |
| preset_val_i | input | 12 | BCD preset value, hundreds/tens/ones |
| count_o | output | 12 | BCD occupancy, hundreds/tens/ones |
| vacancy_o | output | 1 | Spaces available lamp |
| full_o | output | 1 | Lot full lamp |

## Verification
The hardest situation to reach from the ports is a preset request that falls in exactly the cycle in which a synchronized gate event is active, because that event emerges only after the synchronizer and edge detector. The bench closes a switch on a falling edge, counts the two following rising edges, and raises the preset for the single cycle whose sampling edge meets the edge pulse. It then confirms that a valid preset wins outright and that a rejected preset drops the event. Carry and borrow across two digits at once are reached by presetting 099 and 100 before firing a gate.

// File: rtl/park_pkg.sv
package park_pkg;

    localparam int DIGITS  = 3;
    localparam int DIGIT_W = 4;
    localparam int DW      = DIGITS * DIGIT_W;

    typedef logic [DIGIT_W-1:0] digit_t;
    typedef digit_t [DIGITS-1:0] occ_t;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_CLEAR,
        ACT_LOAD,
        ACT_UP,
        ACT_DOWN
    } act_e;

    // binary to packed decimal digits, least significant digit at index 0
    function automatic occ_t bin_to_bcd(input int value);
        occ_t r;
        int   v;
        v = value;
        for (int i = 0; i < DIGITS; i++) begin
            r[i] = digit_t'(v % 10);
            v    = v / 10;
        end
        return r;
    endfunction

    function automatic logic digits_ok(input occ_t v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < DIGITS; i++) begin
            if (v[i] > digit_t'(9)) ok = 1'b0;
        end
        return ok;
    endfunction

    function automatic int bcd_to_bin(input occ_t v);
        int acc;
        acc = 0;
        for (int i = DIGITS - 1; i >= 0; i--) begin
            acc = acc * 10 + int'(v[i]);
        end
        return acc;
    endfunction

endpackage

// File: rtl/park_sync.sv
module park_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sw_i,
    output logic pulse_o
);

    // STAGES synchronizer flops plus one history flop for edge detection
    logic [STAGES:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[STAGES-1:0], sw_i};
        end
    end

    assign pulse_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];

    // one closure yields a pulse one cycle wide
    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        pulse_o |=> !pulse_o);

endmodule

// File: rtl/park_decade.sv
module park_decade
    import park_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clr_i,
    input  logic   load_i,
    input  digit_t load_val_i,
    input  logic   up_i,
    input  logic   dn_i,
    output digit_t digit_o,
    output logic   carry_o,
    output logic   borrow_o
);

    localparam digit_t TOP = digit_t'(9);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            digit_o <= '0;
        end else if (load_i) begin
            digit_o <= load_val_i;
        end else if (up_i) begin
            digit_o <= (digit_o == TOP) ? '0 : digit_o + digit_t'(1);
        end else if (dn_i) begin
            digit_o <= (digit_o == '0) ? TOP : digit_o - digit_t'(1);
        end
    end

    assign carry_o  = up_i & (digit_o == TOP);
    assign borrow_o = dn_i & (digit_o == '0);

    assert_digit_bcd_R4: assert property (@(posedge clk) disable iff (rst)
        digit_o <= TOP);

    assert_up_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (up_i && !clr_i && !load_i && digit_o == TOP) |=> digit_o == '0);

    assert_down_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (dn_i && !up_i && !clr_i && !load_i && digit_o == '0) |=> digit_o == TOP);

endmodule

// File: rtl/park_ctrl.sv
module park_ctrl
    import park_pkg::*;
#(
    parameter int CAPACITY = 100
) (
    input  logic clear_i,
    input  logic preset_en_i,
    input  occ_t preset_val_i,
    input  logic entry_ev_i,
    input  logic exit_ev_i,
    input  occ_t count_i,
    output act_e act_o,
    output logic full_o
);

    localparam occ_t CAP_BCD = bin_to_bcd(CAPACITY);

    logic empty;
    logic preset_ok;

    assign full_o    = (count_i == CAP_BCD);
    assign empty     = (count_i == '0);
    assign preset_ok = digits_ok(preset_val_i) && (bcd_to_bin(preset_val_i) <= CAPACITY);

    always_comb begin
        act_o = ACT_HOLD;
        if (clear_i) begin
            act_o = ACT_CLEAR;
        end else if (preset_en_i) begin
            act_o = preset_ok ? ACT_LOAD : ACT_HOLD;
        end else if (entry_ev_i && !exit_ev_i && !full_o) begin
            act_o = ACT_UP;
        end else if (exit_ev_i && !entry_ev_i && !empty) begin
            act_o = ACT_DOWN;
        end
    end

endmodule

// File: rtl/park_occupancy.sv
module park_occupancy
    import park_pkg::*;
#(
    parameter int CAPACITY    = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     entry_sw_i,
    input  logic                     exit_sw_i,
    input  logic                     clear_i,
    input  logic                     preset_en_i,
    input  logic [park_pkg::DW-1:0]  preset_val_i,
    output logic [park_pkg::DW-1:0]  count_o,
    output logic                     vacancy_o,
    output logic                     full_o
);

    localparam int NSW = 2;   // index 0 entry, index 1 exit

    logic [NSW-1:0]  sw_raw;
    logic [NSW-1:0]  sw_ev;
    occ_t            count;
    occ_t            preset_val;
    act_e            act;
    logic [DIGITS:0] up_chain;
    logic [DIGITS:0] dn_chain;

    assign sw_raw     = {exit_sw_i, entry_sw_i};
    assign preset_val = preset_val_i;

    for (genvar s = 0; s < NSW; s++) begin : g_sw
        park_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst     (rst),
            .sw_i    (sw_raw[s]),
            .pulse_o (sw_ev[s])
        );
    end

    park_ctrl #(.CAPACITY(CAPACITY)) u_ctrl (
        .clear_i      (clear_i),
        .preset_en_i  (preset_en_i),
        .preset_val_i (preset_val),
        .entry_ev_i   (sw_ev[0]),
        .exit_ev_i    (sw_ev[1]),
        .count_i      (count),
        .act_o        (act),
        .full_o       (full_o)
    );

    assign up_chain[0] = (act == ACT_UP);
    assign dn_chain[0] = (act == ACT_DOWN);

    for (genvar d = 0; d < DIGITS; d++) begin : g_digit
        park_decade u_decade (
            .clk        (clk),
            .rst        (rst),
            .clr_i      (act == ACT_CLEAR),
            .load_i     (act == ACT_LOAD),
            .load_val_i (preset_val[d]),
            .up_i       (up_chain[d]),
            .dn_i       (dn_chain[d]),
            .digit_o    (count[d]),
            .carry_o    (up_chain[d+1]),
            .borrow_o   (dn_chain[d+1])
        );
    end

    assign count_o   = count;
    assign vacancy_o = ~full_o;

    assert_clear_zero_R1: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> count_o == '0);

    assert_in_range_R5: assert property (@(posedge clk) disable iff (rst)
        bcd_to_bin(count) <= CAPACITY);

    assert_full_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (full_o && sw_ev[0] && !sw_ev[1] && !clear_i && !preset_en_i) |=> full_o);

    assert_cancel_R6: assert property (@(posedge clk) disable iff (rst)
        (sw_ev[0] && sw_ev[1] && !clear_i && !preset_en_i) |=> $stable(count_o));

    assert_bad_preset_R8: assert property (@(posedge clk) disable iff (rst)
        (preset_en_i && !clear_i && act == ACT_HOLD) |=> $stable(count_o));

    assert_full_source_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(full_o) |-> ($past(act) == ACT_UP || $past(act) == ACT_LOAD));

endmodule

// File: tb/test_park_occupancy.sv
module test_park_occupancy;

    logic        clk = 1'b0;
    logic        rst;
    logic        entry_sw, exit_sw, clear, preset_en;
    logic [11:0] preset_val;
    logic [11:0] count;
    logic        vacancy, full;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    park_occupancy i_park_occupancy (
        .clk          (clk),
        .rst          (rst),
        .entry_sw_i   (entry_sw),
        .exit_sw_i    (exit_sw),
        .clear_i      (clear),
        .preset_en_i  (preset_en),
        .preset_val_i (preset_val),
        .count_o      (count),
        .vacancy_o    (vacancy),
        .full_o       (full)
    );

    task automatic chk_cnt(input string req, input logic [11:0] exp);
        total++;
        if (count !== exp) begin
            bad++;
            $display("FAIL %s count actual=%03h expected=%03h", req, count, exp);
        end
    endtask

    task automatic chk_lamps(input string req, input logic exp_full);
        total++;
        if (full !== exp_full || vacancy !== !exp_full) begin
            bad++;
            $display("FAIL %s lamps actual full=%b vac=%b expected full=%b vac=%b",
                     req, full, vacancy, exp_full, !exp_full);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // close the chosen switches, keep them closed, then open them again
    task automatic gate(input logic en, input logic ex, input int hold);
        @(negedge clk);
        entry_sw = en;
        exit_sw  = ex;
        idle(hold);
        entry_sw = 1'b0;
        exit_sw  = 1'b0;
        idle(4);
    endtask

    task automatic preset(input logic [11:0] v);
        @(negedge clk);
        preset_en  = 1'b1;
        preset_val = v;
        @(negedge clk);
        preset_en  = 1'b0;
        idle(1);
    endtask

    // preset asserted for the cycle whose edge meets the entry pulse
    task automatic preset_on_event(input logic [11:0] v);
        @(negedge clk);
        entry_sw = 1'b1;
        idle(2);
        preset_en  = 1'b1;
        preset_val = v;
        @(negedge clk);
        preset_en = 1'b0;
        idle(3);
        entry_sw = 1'b0;
        idle(4);
    endtask

    task automatic t_reset;
        chk_cnt("R1", 12'h000);
        chk_lamps("R9", 1'b0);
    endtask

    task automatic t_entry_held;
        gate(1'b1, 1'b0, 10);
        chk_cnt("R2", 12'h001);
        gate(1'b1, 1'b0, 4);
        chk_cnt("R2", 12'h002);
    endtask

    task automatic t_latency;
        @(negedge clk);
        entry_sw = 1'b1;
        idle(2);
        chk_cnt("R2", 12'h002);
        idle(1);
        chk_cnt("R2", 12'h003);
        entry_sw = 1'b0;
        idle(4);
    endtask

    task automatic t_carry_borrow;
        preset(12'h009);
        chk_cnt("R7", 12'h009);
        gate(1'b1, 1'b0, 4);
        chk_cnt("R4", 12'h010);
        gate(1'b0, 1'b1, 4);
        chk_cnt("R3", 12'h009);
    endtask

    task automatic t_full;
        preset(12'h099);
        chk_lamps("R9", 1'b0);
        gate(1'b1, 1'b0, 4);
        chk_cnt("R4", 12'h100);
        chk_lamps("R9", 1'b1);
        gate(1'b1, 1'b0, 4);
        chk_cnt("R5", 12'h100);
        gate(1'b0, 1'b1, 4);
        chk_cnt("R4", 12'h099);
        chk_lamps("R9", 1'b0);
    endtask

    task automatic t_empty;
        @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        chk_cnt("R1", 12'h000);
        gate(1'b0, 1'b1, 4);
        chk_cnt("R5", 12'h000);
    endtask

    task automatic t_cancel;
        preset(12'h050);
        gate(1'b1, 1'b1, 4);
        chk_cnt("R6", 12'h050);
    endtask

    task automatic t_bad_preset;
        preset(12'h101);
        chk_cnt("R8", 12'h050);
        preset(12'h0A0);
        chk_cnt("R8", 12'h050);
        preset(12'hF00);
        chk_cnt("R8", 12'h050);
        preset_on_event(12'h1FF);
        chk_cnt("R8", 12'h050);
    endtask

    task automatic t_preset_priority;
        preset_on_event(12'h070);
        chk_cnt("R7", 12'h070);
        preset(12'h100);
        chk_cnt("R7", 12'h100);
    endtask

    task automatic t_clear_priority;
        @(negedge clk);
        clear      = 1'b1;
        preset_en  = 1'b1;
        preset_val = 12'h030;
        @(negedge clk);
        clear     = 1'b0;
        preset_en = 1'b0;
        chk_cnt("R1", 12'h000);
        chk_lamps("R9", 1'b0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        rst = 1'b1;
        entry_sw = 1'b0; exit_sw = 1'b0; clear = 1'b0;
        preset_en = 1'b0; preset_val = '0;
        idle(4);
        rst = 1'b0;
        idle(1);
        t_reset();
        t_entry_held();
        t_latency();
        t_carry_borrow();
        t_full();
        t_empty();
        t_cancel();
        t_bad_preset();
        t_preset_priority();
        t_clear_priority();
        finish_run();
    end

    initial begin
        #(200000 * 20);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule